// File: doc/BRIEF.md
# Segmented Thermometer Decoder With Delay Matching

This block turns a full-rate 12-bit offset-binary sample into the switch drive word of a segmented current-steering converter. A new code can be presented on every clock. Code 000h is the lowest output level and FFFh the highest.

The upper four bits select how many of fifteen identical unit cells are switched on. They are decoded in two pipelined stages. The first stage splits them into a one-hot row group and a one-hot column group. The second stage merges those groups into thermometer lines.

The lower eight bits bypass the decoder and drive binary-weighted switches directly. They pass through a delay line whose length equals the decoder latency. Both parts of every sample are captured in one final register bank, so they leave on the same clock edge with minimal skew between switches.

Top module: `seg_therm_decoder`

## Requirements
- R1: Code 000h yields no thermometer line and a zero LSB word. Code FFFh yields all 15 thermometer lines and LSB word FFh.
- R2: The number of asserted thermometer lines equals the value k of code bits [11:8].
- R3: For a given k, exactly thermometer lines 0 to k-1 are set, and every higher line is clear.
- R4: After the first decode stage, the row group and the column group are each exactly one-hot. The row group is taken from code bits [11:10] and the column group from bits [9:8].
- R5: The LSB output lsb_o[7:0] reproduces code bits [7:0] of the same sample.
- R6: A code sampled at clock edge n appears on both outputs after edge n+2. The thermometer part and the LSB part change on the same edge.
- R7: While rst_n is low, both outputs are all zero, which is the drive word of code 000h. The first two samples after release also read as zero.
- R8: A different code is accepted on every clock with no gaps, and each one appears at the output in input order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_i | input | 12 | Offset-binary sample, one per clock |
| therm_o | output | 15 | Unit-cell enables, line i set when i < code[11:8] |
| lsb_o | output | 8 | Binary-weighted switch enables, delay-matched |

## Verification
The bench alternates 000h and FFFh every cycle, which exposes a stuck or lagging line and any skew between the two output halves. It walks each MSB value from 0 to 15 under four low-byte patterns, so the row and column carries at k = 4, 8 and 12 are told apart from their neighbours. An ascending sweep of all 4096 codes and a long pseudo-random run compare the output on every cycle with a queued model, so an ordering or latency error cannot hide. A reset asserted in the middle of traffic shows that the outputs clear and then refill after exactly two samples.

// File: rtl/seg_dec_pkg.sv
package seg_dec_pkg;

  // Number of unit-cell lines for a thermometer segment of the given width.
  function automatic int unsigned therm_lines(input int unsigned seg_bits);
    return (1 << seg_bits) - 1;
  endfunction

  // Bits of the thermometer segment that index columns (lower half).
  function automatic int unsigned col_bits_of(input int unsigned seg_bits);
    return seg_bits / 2;
  endfunction

  // Bits of the thermometer segment that index rows (upper half).
  function automatic int unsigned row_bits_of(input int unsigned seg_bits);
    return seg_bits - (seg_bits / 2);
  endfunction

  // A line at (row, col) is lit when its linear index is below the code value.
  function automatic int unsigned line_index(input int unsigned row,
                                             input int unsigned col,
                                             input int unsigned cols);
    return row * cols + col;
  endfunction

endpackage

// File: rtl/seg_row_col_split.sv
module seg_row_col_split
  import seg_dec_pkg::*;
#(
  parameter int unsigned SEG_W = 4,
  localparam int unsigned ROW_B = row_bits_of(SEG_W),
  localparam int unsigned COL_B = col_bits_of(SEG_W),
  localparam int unsigned ROWS  = 1 << ROW_B,
  localparam int unsigned COLS  = 1 << COL_B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEG_W-1:0] seg_i,
  output logic [ROWS-1:0]  row_hot_o,
  output logic [COLS-1:0]  col_hot_o
);

  logic [ROW_B-1:0] row_sel;
  logic [COL_B-1:0] col_sel;
  logic [ROWS-1:0]  row_hot_d;
  logic [COLS-1:0]  col_hot_d;

  assign row_sel = seg_i[SEG_W-1:COL_B];
  assign col_sel = seg_i[COL_B-1:0];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_hot_d[r] = (row_sel == ROW_B'(r));
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign col_hot_d[c] = (col_sel == COL_B'(c));
  end

  // Reset state decodes code 0: row 0 and column 0 selected.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_hot_o <= ROWS'(1);
      col_hot_o <= COLS'(1);
    end else begin
      row_hot_o <= row_hot_d;
      col_hot_o <= col_hot_d;
    end
  end

  assert_row_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(row_hot_o));
  assert_col_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(col_hot_o));

endmodule

// File: rtl/seg_therm_merge.sv
module seg_therm_merge
  import seg_dec_pkg::*;
#(
  parameter int unsigned SEG_W = 4,
  localparam int unsigned ROW_B   = row_bits_of(SEG_W),
  localparam int unsigned COL_B   = col_bits_of(SEG_W),
  localparam int unsigned ROWS    = 1 << ROW_B,
  localparam int unsigned COLS    = 1 << COL_B,
  localparam int unsigned THERM_W = therm_lines(SEG_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ROWS-1:0]    row_hot_i,
  input  logic [COLS-1:0]    col_hot_i,
  output logic [THERM_W-1:0] therm_o
);

  logic [ROWS-1:0]    row_above;
  logic [COLS-1:0]    col_above;
  logic [THERM_W-1:0] therm_d;

  // row_above[r]: the selected row lies above row r, so row r is fully lit.
  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      row_above[r] = 1'b0;
      for (int j = r + 1; j < ROWS; j++) row_above[r] = row_above[r] | row_hot_i[j];
    end
    for (int c = 0; c < COLS; c++) begin
      col_above[c] = 1'b0;
      for (int j = c + 1; j < COLS; j++) col_above[c] = col_above[c] | col_hot_i[j];
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_r
    for (genvar c = 0; c < COLS; c++) begin : g_c
      localparam int unsigned IDX = line_index(r, c, COLS);
      if (IDX < THERM_W) begin : g_line
        assign therm_d[IDX] = row_above[r] | (row_hot_i[r] & col_above[c]);
      end
    end
  end

  // Output retiming register for the unit-cell enables.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) therm_o <= '0;
    else        therm_o <= therm_d;
  end

  assert_therm_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (therm_o & (therm_o + THERM_W'(1))) == '0);

endmodule

// File: rtl/seg_delay_line.sv
module seg_delay_line #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] dout_o
);

  logic [WIDTH-1:0] pipe_q [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[s] <= '0;
        else        pipe_q[s] <= din_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[s] <= '0;
        else        pipe_q[s] <= pipe_q[s-1];
      end
    end
  end

  assign dout_o = pipe_q[DEPTH-1];

endmodule

// File: rtl/seg_therm_decoder.sv
module seg_therm_decoder
  import seg_dec_pkg::*;
#(
  parameter int unsigned CODE_W = 12,
  parameter int unsigned SEG_W  = 4,
  localparam int unsigned LSB_W   = CODE_W - SEG_W,
  localparam int unsigned THERM_W = therm_lines(SEG_W),
  localparam int unsigned ROWS    = 1 << row_bits_of(SEG_W),
  localparam int unsigned COLS    = 1 << col_bits_of(SEG_W),
  localparam int unsigned LATENCY = 2,
  localparam int unsigned FILL_W  = $clog2(LATENCY + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CODE_W-1:0]  code_i,
  output logic [THERM_W-1:0] therm_o,
  output logic [LSB_W-1:0]   lsb_o
);

  logic [SEG_W-1:0] seg_code;
  logic [LSB_W-1:0] bin_code;
  logic [ROWS-1:0]  row_hot;
  logic [COLS-1:0]  col_hot;

  assign seg_code = code_i[CODE_W-1:LSB_W];
  assign bin_code = code_i[LSB_W-1:0];

  seg_row_col_split #(.SEG_W(SEG_W)) u_split (
    .clk       (clk),
    .rst_n     (rst_n),
    .seg_i     (seg_code),
    .row_hot_o (row_hot),
    .col_hot_o (col_hot)
  );

  seg_therm_merge #(.SEG_W(SEG_W)) u_merge (
    .clk       (clk),
    .rst_n     (rst_n),
    .row_hot_i (row_hot),
    .col_hot_i (col_hot),
    .therm_o   (therm_o)
  );

  // Binary segment delayed by the decoder latency; last stage is the retime.
  seg_delay_line #(.WIDTH(LSB_W), .DEPTH(LATENCY)) u_lsb_delay (
    .clk    (clk),
    .rst_n  (rst_n),
    .din_i  (bin_code),
    .dout_o (lsb_o)
  );

  // Cycles since reset release, saturating at the pipeline depth.
  logic [FILL_W-1:0] fill_q;
  logic              pipe_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         fill_q <= '0;
    else if (fill_q != FILL_W'(LATENCY)) fill_q <= fill_q + FILL_W'(1);
  end

  assign pipe_full = (fill_q == FILL_W'(LATENCY));

  assert_therm_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_full |-> ($countones(therm_o) == int'($past(seg_code, 2))));

  assert_lsb_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_full |-> (lsb_o == $past(bin_code, 2)));

endmodule

// File: tb/seg_therm_decoder_tb.sv
module seg_therm_decoder_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] code = '0;
  logic [14:0] therm;
  logic [7:0]  lsb;

  int checks = 0;
  int errors = 0;

  // Model: codes entered on the last two negedges, with validity flags.
  logic [11:0] h0 = '0, h1 = '0;
  bit          v0 = 1'b0, v1 = 1'b0;
  string       phase = "R7 reset";
  int unsigned lfsr = 32'h1ACE5EED;

  always #4 clk = ~clk;

  seg_therm_decoder u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .code_i  (code),
    .therm_o (therm),
    .lsb_o   (lsb)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_outputs();
    logic [14:0] exp_t;
    logic [7:0]  exp_l;
    string       tag;
    if (v1) begin
      exp_t = 15'((32'd1 << h1[11:8]) - 32'd1);
      exp_l = h1[7:0];
      tag   = phase;
      if (h1 == 12'h000 || h1 == 12'hFFF) tag = {"R1 ", tag};
    end else begin
      exp_t = '0;
      exp_l = '0;
      tag   = "R7 reset clear";
    end
    chk({"R2 R3 therm ", tag}, 32'(therm), 32'(exp_t));
    chk({"R5 R6 lsb ", tag}, 32'(lsb), 32'(exp_l));
  endtask

  task automatic step(input logic [11:0] c, input logic r);
    @(negedge clk);
    check_outputs();
    rst_n = r;
    code  = c;
    h1 = h0; v1 = v0;
    h0 = c;  v0 = r;
    if (!r) v1 = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 3; i++) step(12'h000, 1'b0);

    phase = "R1 extremes";
    for (int i = 0; i < 8; i++) begin
      step(12'h000, 1'b1);
      step(12'hFFF, 1'b1);
    end
    step(12'h0FF, 1'b1);
    step(12'hF00, 1'b1);

    phase = "R4 row/col boundary";
    for (int k = 0; k < 16; k++) begin
      step({4'(k), 8'h00}, 1'b1);
      step({4'(k), 8'hFF}, 1'b1);
      step({4'(k), 8'h55}, 1'b1);
      step({4'(k), 8'hAA}, 1'b1);
    end

    phase = "R8 back-to-back sweep";
    for (int i = 0; i < 4096; i++) step(12'(i), 1'b1);

    phase = "R7 mid-run reset";
    step(12'hFFF, 1'b1);
    step(12'hABC, 1'b0);
    step(12'h5A5, 1'b0);
    step(12'h123, 1'b1);
    step(12'h456, 1'b1);
    step(12'h789, 1'b1);

    phase = "R8 pseudo-random";
    for (int i = 0; i < 1500; i++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      step(lfsr[11:0], 1'b1);
    end

    phase = "R6 drain";
    for (int i = 0; i < 3; i++) step(12'h000, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule